// File: doc/BRIEF.md
# Grouped-Priority Interrupt Level Controller

This block collects interrupt requests for eight levels, numbered 0 to 7, and keeps one sticky pending bit per level. A per-level mask and a global enable gate the pending bits, and the surviving levels compete in two stages. First, the levels belong to three fixed groups: group A holds levels 0 and 1, group B holds levels 2 to 4, and group C holds levels 5 to 7. A programmable field orders the groups, and further fields order the members inside each group. The controller drives one request line toward the processor together with the number of the winning level.

The processor services the request. It then returns an acknowledge carrying the serviced level number, which clears that pending bit. Software reaches the mask, priority, pending and system-mode registers through a small synchronous write / combinational read bus. Two dedicated command inputs set and clear the global enable, the way enable-interrupt and disable-interrupt instructions would.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask, priority, pending and system-mode registers all read 0, so irqReq is 0 and global interrupt processing stays off until it is enabled.
- R2: A 1 on levelSet[i] at a clock edge sets pending bit i, which then holds until it is cleared. The pending register at bus address 2 shows level i in bit i. Bus writes to address 2 have no effect.
- R3: ackValid with level number ackLevel clears that level's pending bit at the same edge. A levelSet pulse for the same level at that edge wins, and the bit stays 1.
- R4: The mask register sits at bus address 0, and bit i = 1 unmasks level i. A masked level never causes a request, but its pending bit is still recorded.
- R5: The system-mode register sits at bus address 3. Bit 0 is the global enable and bit 1 is a fast-interrupt enable that is only stored and read back. Bits 7:2 read 0. gieSet sets bit 0 and gieClr clears it. gieClr wins over gieSet, and either command wins over a bus write to bit 0 at the same edge.
- R6: irqReq is 1 exactly when the registered global enable is 1 and at least one pending level is unmasked. A register change made at an edge shows on irqReq from that edge on, and never earlier.
- R7: Priority register (bus address 1) bits 2:0 select the group order, highest first: 0 A,B,C; 1 A,C,B; 2 B,A,C; 3 B,C,A; 4 C,A,B; 5 C,B,A. Values 6 and 7 behave as 0.
- R8: Priority bit 3 = 1 ranks level 1 above level 0 inside group A. When it is 0, level 0 ranks first.
- R9: Priority bits 5:4 give the index (0 to 2, with 3 treated as 0) of the group B member that ranks highest: level 2 plus the index. The other two members of group B follow in ascending order.
- R10: Priority bits 7:6 choose the highest-ranking member of group C in the same way, counting from level 5. The other two members follow in ascending order.
- R11: When irqReq is 1, irqLevel is the highest-ranked level that is both pending and unmasked. When irqReq is 0, irqLevel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| levelSet | input | 8 | Per-level set pulses for the pending bits |
| ackValid | input | 1 | Acknowledge of a serviced level |
| ackLevel | input | 3 | Level number being acknowledged |
| gieSet | input | 1 | Enable-interrupts command |
| gieClr | input | 1 | Disable-interrupts command |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 mask, 1 priority, 2 pending, 3 system mode) |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr, combinational |
| irqReq | output | 1 | Interrupt request to the processor |
| irqLevel | output | 3 | Winning level number |

## Verification
Every register update lands on the clock edge that samples the stimulus. irqReq and irqLevel are decoded combinationally from those registers, so both change one edge after a set pulse, acknowledge, command or bus write. busRdData follows busAddr in the same cycle. The bench drives inputs after a falling edge and compares all three outputs a nanosecond later against a behavioural model. It advances that model at the next rising edge, so each expected value stands for exactly the registered state that the design holds. The priority sweep walks all 256 priority codes with every level pending.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int LEVELS = 8;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  // fixed level groups
  localparam int GRP_A_BASE = 0;
  localparam int GRP_A_SIZE = 2;
  localparam int GRP_B_BASE = GRP_A_BASE + GRP_A_SIZE;
  localparam int GRP_B_SIZE = 3;
  localparam int GRP_C_BASE = GRP_B_BASE + GRP_B_SIZE;
  localparam int GRP_C_SIZE = LEVELS - GRP_C_BASE;
  localparam int NUM_GRPS   = 3;

  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PRIO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_SYS  = ADDR_W'(3);

  localparam int SYS_W        = 2;
  localparam int SYS_GIE_BIT  = 0;
  localparam int SYS_FAST_BIT = 1;

  typedef enum logic [1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_C = 2'd2} grpId_e;

  // priority register layout (MSB first)
  typedef struct packed {
    logic [1:0] topC;
    logic [1:0] topB;
    logic       swapA;
    logic [2:0] order;
  } prioField_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrMask;
    logic              wrPrio;
    logic              wrSys;
    logic              gieSet;
    logic              gieClr;
    logic [LEVELS-1:0] ackClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/lvl_irq_ctrl_unit.sv
module lvl_irq_ctrl_unit
  import lvl_irq_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic              gieSet,
  input  logic              gieClr,
  output ctrlStrobe_t       strobe
);

  logic [LEVELS-1:0] ackVec;

  generate
    for (genvar i = 0; i < LEVELS; i++) begin : g_ack
      assign ackVec[i] = ackValid && (ackLevel == LVL_W'(i));
    end
  endgenerate

  always_comb begin
    strobe        = '0;
    strobe.wrMask = busWrEn && (busAddr == ADDR_MASK);
    strobe.wrPrio = busWrEn && (busAddr == ADDR_PRIO);
    strobe.wrSys  = busWrEn && (busAddr == ADDR_SYS);
    strobe.gieSet = gieSet;
    strobe.gieClr = gieClr;
    strobe.ackClr = ackVec;
  end

endmodule

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LEVELS-1:0] levelSet,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [LEVELS-1:0] maskQ,
  output logic [DATA_W-1:0] prioQ,
  output logic [LEVELS-1:0] pendQ,
  output logic [SYS_W-1:0]  sysQ,
  output logic [DATA_W-1:0] busRdData
);

  // sticky pending bits, set beats clear
  generate
    for (genvar i = 0; i < LEVELS; i++) begin : g_pend
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                pendQ[i] <= 1'b0;
        else if (levelSet[i])     pendQ[i] <= 1'b1;
        else if (strobe.ackClr[i]) pendQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      prioQ <= '0;
    end else begin
      if (strobe.wrMask) maskQ <= busWrData[LEVELS-1:0];
      if (strobe.wrPrio) prioQ <= busWrData;
    end
  end

  // global enable: commands override the bus, clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysQ <= '0;
    end else begin
      if (strobe.gieClr)      sysQ[SYS_GIE_BIT] <= 1'b0;
      else if (strobe.gieSet) sysQ[SYS_GIE_BIT] <= 1'b1;
      else if (strobe.wrSys)  sysQ[SYS_GIE_BIT] <= busWrData[SYS_GIE_BIT];
      if (strobe.wrSys)       sysQ[SYS_FAST_BIT] <= busWrData[SYS_FAST_BIT];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_MASK: busRdData = DATA_W'(maskQ);
      ADDR_PRIO: busRdData = prioQ;
      ADDR_PEND: busRdData = DATA_W'(pendQ);
      default:   busRdData = DATA_W'(sysQ);
    endcase
  end

endmodule

// File: rtl/lvl_irq_resolver.sv
module lvl_irq_resolver
  import lvl_irq_pkg::*;
(
  input  logic [LEVELS-1:0] activeLvl,
  input  logic [DATA_W-1:0] prioRaw,
  output logic              irqReq,
  output logic [LVL_W-1:0]  irqLevel
);

  prioField_t prio;
  assign prio = prioField_t'(prioRaw);

  // three-member group ordering: chosen top first, rest ascending
  function automatic logic [GRP_B_SIZE-1:0][LVL_W-1:0] trioOrder(input int base,
                                                                input logic [1:0] top);
    logic [GRP_B_SIZE-1:0][LVL_W-1:0] res;
    int t;
    int k;
    t = (top == 2'd3) ? 0 : int'(top);
    res = '0;
    res[0] = LVL_W'(base + t);
    k = 1;
    for (int j = 0; j < GRP_B_SIZE; j++) begin
      if (j != t) begin
        res[k] = LVL_W'(base + j);
        k++;
      end
    end
    return res;
  endfunction

  logic [GRP_A_SIZE-1:0][LVL_W-1:0] aOrd;
  logic [GRP_B_SIZE-1:0][LVL_W-1:0] bOrd;
  logic [GRP_C_SIZE-1:0][LVL_W-1:0] cOrd;
  grpId_e grpSeq [NUM_GRPS];
  logic [LEVELS-1:0][LVL_W-1:0] rankList;

  always_comb begin
    aOrd[0] = prio.swapA ? LVL_W'(GRP_A_BASE + 1) : LVL_W'(GRP_A_BASE);
    aOrd[1] = prio.swapA ? LVL_W'(GRP_A_BASE) : LVL_W'(GRP_A_BASE + 1);
    bOrd    = trioOrder(GRP_B_BASE, prio.topB);
    cOrd    = trioOrder(GRP_C_BASE, prio.topC);
  end

  always_comb begin
    case (prio.order)
      3'd1:    begin grpSeq[0] = GRP_A; grpSeq[1] = GRP_C; grpSeq[2] = GRP_B; end
      3'd2:    begin grpSeq[0] = GRP_B; grpSeq[1] = GRP_A; grpSeq[2] = GRP_C; end
      3'd3:    begin grpSeq[0] = GRP_B; grpSeq[1] = GRP_C; grpSeq[2] = GRP_A; end
      3'd4:    begin grpSeq[0] = GRP_C; grpSeq[1] = GRP_A; grpSeq[2] = GRP_B; end
      3'd5:    begin grpSeq[0] = GRP_C; grpSeq[1] = GRP_B; grpSeq[2] = GRP_A; end
      default: begin grpSeq[0] = GRP_A; grpSeq[1] = GRP_B; grpSeq[2] = GRP_C; end
    endcase
  end

  // flatten group sequence into a full rank list, rank 0 highest
  always_comb begin
    int pos;
    pos = 0;
    rankList = '0;
    for (int s = 0; s < NUM_GRPS; s++) begin
      case (grpSeq[s])
        GRP_A: for (int j = 0; j < GRP_A_SIZE; j++) begin
                 rankList[pos] = aOrd[j];
                 pos++;
               end
        GRP_B: for (int j = 0; j < GRP_B_SIZE; j++) begin
                 rankList[pos] = bOrd[j];
                 pos++;
               end
        default: for (int j = 0; j < GRP_C_SIZE; j++) begin
                 rankList[pos] = cOrd[j];
                 pos++;
               end
      endcase
    end
  end

  // scan from lowest rank up so the highest-ranked active level is kept
  always_comb begin
    irqReq   = |activeLvl;
    irqLevel = '0;
    for (int r = LEVELS - 1; r >= 0; r--) begin
      if (activeLvl[rankList[r]]) irqLevel = rankList[r];
    end
  end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS-1:0] levelSet,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic              gieSet,
  input  logic              gieClr,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq,
  output logic [LVL_W-1:0]  irqLevel
);

  ctrlStrobe_t       strobe;
  logic [LEVELS-1:0] maskQ;
  logic [DATA_W-1:0] prioQ;
  logic [LEVELS-1:0] pendQ;
  logic [SYS_W-1:0]  sysQ;
  logic [LEVELS-1:0] activeLvl;

  lvl_irq_ctrl_unit ctrl_i (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .ackValid(ackValid),
    .ackLevel(ackLevel),
    .gieSet  (gieSet),
    .gieClr  (gieClr),
    .strobe  (strobe)
  );

  lvl_irq_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .levelSet (levelSet),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .maskQ    (maskQ),
    .prioQ    (prioQ),
    .pendQ    (pendQ),
    .sysQ     (sysQ),
    .busRdData(busRdData)
  );

  assign activeLvl = pendQ & maskQ & {LEVELS{sysQ[SYS_GIE_BIT]}};

  lvl_irq_resolver res_i (
    .activeLvl(activeLvl),
    .prioRaw  (prioQ),
    .irqReq   (irqReq),
    .irqLevel (irqLevel)
  );

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [LEVELS-1:0] levelSet,
  input logic              ackValid,
  input logic [LVL_W-1:0]  ackLevel,
  input logic              gieSet,
  input logic              gieClr,
  input logic              irqReq,
  input logic [LVL_W-1:0]  irqLevel,
  input logic [LEVELS-1:0] maskQ,
  input logic [LEVELS-1:0] pendQ,
  input logic [SYS_W-1:0]  sysQ
);

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|levelSet) |=> ((pendQ & $past(levelSet)) == $past(levelSet)));  // R2

  AST_NO_SPONTANEOUS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(levelSet)) == '0));  // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !levelSet[ackLevel]) |=> !pendQ[$past(ackLevel)]);  // R3

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & maskQ) == '0) |-> !irqReq);  // R4

  AST_GIE_SET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (gieSet && !gieClr) |=> sysQ[SYS_GIE_BIT]);  // R5

  AST_GIE_CLR_CMD: assert property (@(posedge clk) disable iff (!rstN)
    gieClr |=> !sysQ[SYS_GIE_BIT]);  // R5

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !sysQ[SYS_GIE_BIT] |-> !irqReq);  // R6

  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendQ[irqLevel] && maskQ[irqLevel]));  // R11

  AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqLevel == '0));  // R11

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .levelSet(levelSet),
  .ackValid(ackValid),
  .ackLevel(ackLevel),
  .gieSet  (gieSet),
  .gieClr  (gieClr),
  .irqReq  (irqReq),
  .irqLevel(irqLevel),
  .maskQ   (maskQ),
  .pendQ   (pendQ),
  .sysQ    (sysQ)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] levelSet = '0;
  logic       ackValid = 1'b0;
  logic [2:0] ackLevel = '0;
  logic       gieSet = 1'b0;
  logic       gieClr = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irqReq;
  logic [2:0] irqLevel;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  logic [7:0] mMask = '0, mPrio = '0, mPend = '0;
  logic       mGie = 1'b0, mFast = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lvl_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .levelSet(levelSet), .ackValid(ackValid),
    .ackLevel(ackLevel), .gieSet(gieSet), .gieClr(gieClr), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq), .irqLevel(irqLevel)
  );

  task automatic checkVal(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int grpPos(int ord, int g);
    int o;
    o = (ord > 5) ? 0 : ord;
    case (o)
      0: return g;                                 // A B C
      1: return (g == 0) ? 0 : (g == 2) ? 1 : 2;   // A C B
      2: return (g == 1) ? 0 : (g == 0) ? 1 : 2;   // B A C
      3: return (g == 1) ? 0 : (g == 2) ? 1 : 2;   // B C A
      4: return (g == 2) ? 0 : (g == 0) ? 1 : 2;   // C A B
      default: return (g == 2) ? 0 : (g == 1) ? 1 : 2; // C B A
    endcase
  endfunction

  function automatic int memberRank(int lv, logic [7:0] p);
    int idx, top;
    if (lv < 2) return (p[3] ? (1 - lv) : lv);
    if (lv < 5) begin idx = lv - 2; top = p[5:4]; end
    else        begin idx = lv - 5; top = p[7:6]; end
    if (top == 3) top = 0;
    if (idx == top) return 0;
    return (idx < top) ? idx + 1 : idx;
  endfunction

  function automatic int expLevel(logic [7:0] act, logic [7:0] p);
    int best, bestScore, g, sc;
    best = 0; bestScore = 1000;
    for (int lv = 0; lv < 8; lv++) begin
      if (act[lv]) begin
        g  = (lv < 2) ? 0 : (lv < 5) ? 1 : 2;
        sc = grpPos(int'(p[2:0]), g) * 3 + memberRank(lv, p);
        if (sc < bestScore) begin bestScore = sc; best = lv; end
      end
    end
    return best;
  endfunction

  task automatic compareAll();
    logic [7:0] act;
    int expRd;
    act = mPend & mMask & {8{mGie}};
    checkVal("R6 irqReq", int'(irqReq), int'(|act));
    checkVal("R7/R8/R9/R10/R11 irqLevel", int'(irqLevel), expLevel(act, mPrio));
    case (busAddr)
      2'd0: begin expRd = mMask; checkVal("R4 mask read", busRdData, expRd); end
      2'd1: begin expRd = mPrio; checkVal("R7 prio read", busRdData, expRd); end
      2'd2: begin expRd = mPend; checkVal("R2 pend read", busRdData, expRd); end
      default: begin expRd = {6'b0, mFast, mGie}; checkVal("R5 sys read", busRdData, expRd); end
    endcase
  endtask

  task automatic modelEdge();
    for (int lv = 0; lv < 8; lv++) begin
      if (levelSet[lv]) mPend[lv] = 1'b1;
      else if (ackValid && ackLevel == 3'(lv)) mPend[lv] = 1'b0;
    end
    if (busWrEn && busAddr == 2'd0) mMask = busWrData;
    if (busWrEn && busAddr == 2'd1) mPrio = busWrData;
    if (gieClr) mGie = 1'b0;
    else if (gieSet) mGie = 1'b1;
    else if (busWrEn && busAddr == 2'd3) mGie = busWrData[0];
    if (busWrEn && busAddr == 2'd3) mFast = busWrData[1];
  endtask

  // inputs are driven before calling; compare, clock, advance model
  task automatic cycle();
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    levelSet = '0; ackValid = 0; gieSet = 0; gieClr = 0; busWrEn = 0;
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    idleInputs();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    cycle();
    busWrEn = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on every register and the request
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a);
      #1 checkVal("R1 reset read", busRdData, 0);
      checkVal("R1 reset irqReq", irqReq, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R4: pending recorded while masked, no request
    levelSet = 8'hA5; busAddr = 2'd2; cycle(); idleInputs();
    gieSet = 1'b1; cycle(); gieSet = 0;
    checkVal("R4 masked pend visible", busRdData, 8'hA5);
    checkVal("R4 masked no request", irqReq, 0);
    cycle();

    // R2: writes to pending address ignored
    busWrite(2'd2, 8'h00);
    busAddr = 2'd2; cycle();
    checkVal("R2 pend write ignored", busRdData, 8'hA5);

    // R6: unmask -> request one edge later
    busWrite(2'd0, 8'hFF);
    busAddr = 2'd0; cycle();

    // R7 R8 R9 R10: all 256 priority codes with all levels pending
    levelSet = 8'hFF; cycle(); idleInputs();
    for (int p = 0; p < 256; p++) begin
      busWrite(2'd1, 8'(p));
      busAddr = 2'd1; cycle();
    end

    // R3: ack clears; simultaneous set wins
    busWrite(2'd1, 8'h00);
    ackValid = 1; ackLevel = 3'd0; busAddr = 2'd2; cycle(); idleInputs();
    checkVal("R3 ack cleared level 0", busRdData[0], 0);
    ackValid = 1; ackLevel = 3'd1; levelSet = 8'h02; cycle(); idleInputs();
    checkVal("R3 set wins over ack", busRdData[1], 1);
    cycle();

    // R5: command vs bus write conflicts, fast bit stored only
    busAddr = 2'd3; busWrData = 8'hFE; busWrEn = 1; gieSet = 1; cycle(); idleInputs();
    checkVal("R5 set beats write", busRdData, 8'h03);
    gieSet = 1; gieClr = 1; cycle(); idleInputs();
    checkVal("R5 clear wins", busRdData, 8'h02);
    checkVal("R6 disabled no request", irqReq, 0);
    busWrite(2'd3, 8'h01);
    busAddr = 2'd3; cycle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      levelSet = (r < 30) ? 8'($urandom) & 8'($urandom) : 8'h00;
      ackValid = ($urandom_range(0, 2) == 0);
      ackLevel = 3'($urandom);
      gieSet   = ($urandom_range(0, 15) == 0);
      gieClr   = ($urandom_range(0, 19) == 0);
      busWrEn  = ($urandom_range(0, 5) == 0);
      busAddr  = 2'($urandom);
      busWrData = 8'($urandom);
      cycle();
    end
    idleInputs();
    cycle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule